// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation analog-to-digital converter. Its result is 16 bits wide by default. The DAC, the comparator and the input scaling stay outside the block. A conversion is requested with a pulse on `conv_start`, and it begins on the pulse's trailing (1 to 0) edge. The block then enables a gated copy of the system clock and makes one trial-and-decide step per clock edge. In each step it uses a single comparator bit that reports whether the analog input is at or above the level of the current trial word.

The trial word drives the external DAC and is also the parallel result. All data is negative-true: a register bit at 0 stands for a logical one. A serial NRZ copy of the result leaves on `ser_out`, MSB first, and changes on the same rising edges that settle the parallel bits. A receiver clocked on the falling edges of `gclk_out` therefore ends up holding the result. The coding reads as straight binary or offset binary, depending on how the analog front end is scaled. The digital sequence is the same in both cases.

`busy` is high for the whole conversion. It drops on the edge that latches the LSB, and that same edge stops the gated clock. The gated clock then stays low until the next conversion starts.

Top module: `sar_seq_top`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` is 0, `result` is all ones, `ser_out` is 1 and `gclk_out` is low.
- R2: When idle, a trailing edge of `conv_start` (1 in the previous clock cycle, 0 now, sampled on the rising `clk` edge) starts a conversion on that edge. `busy` rises and `result` becomes all ones.
- R3: On the next rising edge (the seed step), `result` holds the MSB at 0 and all other bits at 1 (0x7FFF for 16 bits), and `ser_out` drives a filler 1.
- R4: On each of the following WIDTH rising edges, the bit under decision is settled from MSB down to LSB. With `cmp_keep` = 1 the bit stays 0; with `cmp_keep` = 0 it returns to 1. On the same edge the next lower bit is cleared to 0. The final `result` is the bitwise complement of the code that the comparator implies.
- R5: `busy` falls on the edge that decides the LSB. It stays high for exactly WIDTH+1 clock cycles, and `result` is final when it falls.
- R6: `gclk_out` follows `clk` through the conversion, giving exactly WIDTH+1 high pulses (and WIDTH+1 falling edges). It is low at any time the block is idle.
- R7: `ser_out` changes only on rising edges, and each decided bit appears on the edge that decides it. A WIDTH-bit shift register clocked on the falling edges of `gclk_out` holds `result` at the end of the conversion, because the filler bit has been shifted out.
- R8: A trailing edge of `conv_start` while `busy` is high is ignored. This includes one that arrives on the edge deciding the LSB: `busy` stays low afterwards and `gclk_out` gives no extra pulse.
- R9: While idle, `result` and `ser_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion request; acts on its trailing edge |
| cmp_keep | input | 1 | Comparator decision: 1 keeps the trial bit, 0 restores it |
| gclk_out | output | 1 | Gated conversion clock, low while idle |
| busy | output | 1 | High during a conversion |
| result | output | WIDTH | Trial word and final result, negative-true |
| ser_out | output | 1 | Serial NRZ result, MSB first, negative-true |

## Verification
Two events can fall on the same rising edge: the LSB decision that ends a conversion, and a trailing edge of `conv_start` that asks for a new one. The bench raises and drops `conv_start` so that the drop is seen on exactly that edge. It then checks that the result is still correct, that `busy` stays low and that the gated clock adds no pulse. A request dropped one cycle later must start a normal conversion. A mid-conversion request is checked the same way. A behavioural comparator that targets a stride sweep over the code space, plus the corner codes, compares every final word, every serially received word, every falling-edge count and every busy length against arithmetic expectations.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SEED   = 2'd1,
    PH_DECIDE = 2'd2
  } phase_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  conv_start,
  output logic                                  busy,
  output logic                                  init,
  output logic                                  seed,
  output logic                                  decide,
  output logic [((WIDTH > 1) ? $clog2(WIDTH) : 1)-1:0] idx
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  phase_t          phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            start_prev_q;
  logic            start_fall;
  logic            cnt_en;

  assign start_fall = start_prev_q & ~conv_start;

  // next-state
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_fall) phase_d = PH_SEED;
      end
      PH_SEED: begin
        phase_d = PH_DECIDE;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      PH_DECIDE: begin
        if (cnt_q == LAST) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      cnt_q        <= '0;
      start_prev_q <= 1'b0;
    end else begin
      phase_q      <= phase_d;
      start_prev_q <= conv_start;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy   = (phase_q != PH_IDLE);
  assign init   = (phase_q == PH_IDLE) && start_fall;
  assign seed   = (phase_q == PH_SEED);
  assign decide = (phase_q == PH_DECIDE);
  assign idx    = LAST - cnt_q;

  // R8: a request during the decide phase never disturbs the step sequence
  p_req_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && start_fall && cnt_q != LAST) |=> (decide && cnt_q == $past(cnt_q) + 1'b1));

  // R8: the LSB edge always returns to idle, whatever conv_start does
  p_lsb_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && cnt_q == LAST) |=> !busy);

  // R5: busy only drops after the last decide step
  p_busy_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(decide) && $past(cnt_q) == LAST));

endmodule

// File: rtl/sar_seq_reg.sv
module sar_seq_reg #(
  parameter int WIDTH = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  init,
  input  logic                                  seed,
  input  logic                                  decide,
  input  logic [((WIDTH > 1) ? $clog2(WIDTH) : 1)-1:0] idx,
  input  logic                                  keep,
  output logic [WIDTH-1:0]                      q
);

  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [WIDTH-1:0] SEED_WORD = {1'b0, {(WIDTH-1){1'b1}}};

  logic [WIDTH-1:0] q_q, q_d;
  logic             q_en;

  always_comb begin
    q_d  = q_q;
    q_en = init | seed | decide;
    if (init) begin
      q_d = '1;
    end else if (seed) begin
      q_d = SEED_WORD;
    end else if (decide) begin
      q_d[idx] = ~keep;
      if (idx != '0) q_d[idx - 1'b1] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '1;
    else if (q_en) q_q <= q_d;
  end

  assign q = q_q;

  // R2: a start edge leaves an all-ones word
  p_init_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (q_q == '1));

  // R3: the seed step leaves only the MSB cleared
  p_seed_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> (q_q == SEED_WORD));

  // R4: each non-final decision puts the next lower trial bit in place
  p_next_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && idx != '0) |=> (q_q[$past(idx) - IW'(1)] == 1'b0));

endmodule

// File: rtl/sar_seq_ser.sv
module sar_seq_ser (
  input  logic clk,
  input  logic rst_n,
  input  logic seed,
  input  logic decide,
  input  logic keep,
  output logic ser_out
);

  logic ser_q, ser_d, ser_en;

  always_comb begin
    ser_en = seed | decide;
    ser_d  = ser_q;
    if (seed)        ser_d = 1'b1;
    else if (decide) ser_d = ~keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ser_q <= 1'b1;
    else if (ser_en) ser_q <= ser_d;
  end

  assign ser_out = ser_q;

  // R3: the filler bit driven on the seed edge is a 1
  p_ser_filler_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> ser_q);

endmodule

// File: rtl/sar_seq_clkgate.sv
module sar_seq_clkgate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic gclk
);

  logic en_q;

  // enable changes only while clk is low, so the gated output has no runt pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= run;
  end

  assign gclk = clk & en_q;

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             cmp_keep,
  output logic             gclk_out,
  output logic             busy,
  output logic [WIDTH-1:0] result,
  output logic             ser_out
);

  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic          init, seed, decide;
  logic [IW-1:0] idx;

  sar_seq_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .busy       (busy),
    .init       (init),
    .seed       (seed),
    .decide     (decide),
    .idx        (idx)
  );

  sar_seq_reg #(.WIDTH(WIDTH)) i_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (init),
    .seed   (seed),
    .decide (decide),
    .idx    (idx),
    .keep   (cmp_keep),
    .q      (result)
  );

  sar_seq_ser i_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .seed    (seed),
    .decide  (decide),
    .keep    (cmp_keep),
    .ser_out (ser_out)
  );

  sar_seq_clkgate i_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .gclk  (gclk_out)
  );

  // R9: idle outputs hold
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(result) && $stable(ser_out)));

  // R7: the serial line follows each decided parallel bit on the same edge
  p_ser_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> (ser_out == result[$past(idx)]));

endmodule

// File: tb/test_sar_seq_top.sv
`timescale 1ns/1ps
module test_sar_seq_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         conv_start;
  logic         cmp_keep;
  logic         gclk_out;
  logic         busy;
  logic [W-1:0] result;
  logic         ser_out;

  logic [W-1:0] target;
  logic [W-1:0] rx;
  int           fcount;
  int           total = 0;
  int           bad = 0;
  bit           finished = 0;

  always #2.5 clk = ~clk;

  sar_seq_top #(.WIDTH(W)) i_sar_seq_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .cmp_keep   (cmp_keep),
    .gclk_out   (gclk_out),
    .busy       (busy),
    .result     (result),
    .ser_out    (ser_out)
  );

  // ideal comparator: keep when the target code reaches the trial level
  assign cmp_keep = (target >= W'(~result));

  // receiving shift register on falling edges of the gated clock
  always @(negedge gclk_out) begin
    rx     <= {rx[W-2:0], ser_out};
    fcount <= fcount + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ign: negedge index at which a stray request is raised (dropped one later); 0 = none
  task automatic run_conv(input logic [W-1:0] t, input int ign);
    int busy_cnt = 0;
    bit seen = 0;
    target = t;
    fcount = 0;
    @(negedge clk) conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
    for (int k = 1; k < 60; k++) begin
      @(negedge clk);
      if (k == 1) check(result == '1, "R2", result, {W{1'b1}});
      if (k == 2) check(result == {1'b0, {(W-1){1'b1}}}, "R3", result, {1'b0, {(W-1){1'b1}}});
      if (busy) begin busy_cnt++; seen = 1; end
      if (ign != 0 && k == ign) conv_start = 1'b1;
      if (ign != 0 && k == ign + 1) conv_start = 1'b0;
      if (seen && !busy && k > ign + 1) break;
    end
    check(result == ~t, "R4", result, ~t);
    check(busy_cnt == W + 1, "R5", busy_cnt, W + 1);
    repeat (3) @(negedge clk);
    check(fcount == W + 1, "R6", fcount, W + 1);
    check(rx == ~t, "R7", rx, ~t);
    if (ign != 0) check(!busy, "R8", busy, 0);
    check(result == ~t, "R9", result, ~t);
  endtask

  initial begin
    rst_n = 1'b0;
    conv_start = 1'b0;
    target = '0;
    rx = '0;
    fcount = 0;
    repeat (3) @(negedge clk);
    check(!busy && result == '1 && ser_out && !gclk_out, "R1", {busy, ser_out, gclk_out}, 3'b010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && result == '1 && ser_out, "R1", {busy, ser_out}, 2'b01);
    @(posedge clk) #1;
    check(!gclk_out, "R6 idle low", gclk_out, 0);

    run_conv(16'h0000, 0);
    run_conv(16'hFFFF, 0);
    run_conv(16'h8000, 0);
    run_conv(16'h7FFF, 0);
    run_conv(16'h0001, 0);
    run_conv(16'hA5C3, 5);    // R8 request in mid conversion
    run_conv(16'h3C96, 16);   // R8 request lands on the LSB edge
    run_conv(16'h1234, 0);    // request right after is accepted

    // R6: gated clock high during a conversion
    target = 16'h4321;
    @(negedge clk) conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
    repeat (4) @(negedge clk);
    @(posedge clk) #1;
    check(gclk_out, "R6 running", gclk_out, 1);
    repeat (20) @(negedge clk);
    check(result == ~target, "R4", result, ~target);
    @(posedge clk) #1;
    check(!gclk_out, "R6 idle low", gclk_out, 0);

    for (int c = 3; c < 65536; c += 17) run_conv(W'(c), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule